// File: doc/BRIEF.md
# 2D Window DMA Address Generator

This block produces the byte address streams for a memory-to-memory pixel copy. One start pulse launches a transaction. The read stream walks a source block that is packed contiguously in memory. The write stream places that same block as a rectangular window inside a larger destination picture. Destination bytes outside the window are never addressed, so they keep whatever they already held. A linear mode is also provided. It copies a flat run of bytes whose length is assembled from a high field and a 14-bit low field.

All geometry is taken from the configuration inputs in the cycle where start is accepted. The inputs are free to change after that. Each stream has its own valid/ready handshake, so the read engine and the write engine can each stall independently. A one-cycle done pulse marks the end of a transaction. It carries an end-of-frame qualifier that was captured at start.

Top module: `win_dma_agen`

## Requirements
- R1: After reset, rd_valid, wr_valid and done are all low until a start is accepted.
- R2: In 2D mode the read stream issues blk_w*blk_h*bpp addresses, src_base+0, src_base+1, … in increasing order.
- R3: In 2D mode, byte k of block pixel (wx, wy) is written at dst_base + (pic_w*(off_y+wy) + off_x + wx)*bpp + k. Pixels are visited row by row, left to right, and the bytes of a pixel are visited lowest address first.
- R4: The write stream issues exactly blk_w*blk_h*bpp addresses, and none of them lies outside the window, so destination pixels outside the window are left untouched.
- R5: The 2-bit bpp_code selects the bytes per pixel: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 3 bytes, and 3 is reserved and acts as 1 byte.
- R6: With mode_2d low, both streams issue (len_hi<<14)|len_lo addresses linearly from their bases. In this mode bpp_code and the window fields have no effect.
- R7: A stream's address advances only on a cycle where its valid and ready are both high. While valid is high and ready is low, the stream holds the same address and keeps valid high.
- R8: done is high for exactly one cycle: the cycle after the later of the two final handshakes. Neither stream is valid in that cycle. done_eof equals done AND the eof_flag value captured at start.
- R9: A start pulse that arrives while a transaction is in flight, including in its done cycle, is ignored. The configuration values present at that moment have no effect either.
- R10: A zero block width, zero block height, or zero linear length produces done in the cycle after start, and no address is issued.
- R11: In 2D mode, a window that does not fit the picture (off_x+blk_w > pic_w or off_y+blk_h > pic_h) produces done in the cycle after start, and no address is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| mode_2d | input | 1 | 1 = window copy, 0 = linear copy |
| eof_flag | input | 1 | End-of-frame qualifier, reported on done_eof |
| bpp_code | input | 2 | Bytes-per-pixel code |
| pic_w | input | DIM_W | Destination picture width in pixels |
| pic_h | input | DIM_W | Destination picture height in pixels |
| blk_w | input | DIM_W | Block width in pixels |
| blk_h | input | DIM_W | Block height in pixels |
| off_x | input | DIM_W | Window left column |
| off_y | input | DIM_W | Window top row |
| len_hi | input | HI_W | Linear length, upper part |
| len_lo | input | LO_W | Linear length, low 14 bits |
| src_base | input | AW | Source base byte address |
| dst_base | input | AW | Destination picture base byte address |
| rd_valid | output | 1 | Read address valid |
| rd_ready | input | 1 | Read address accepted |
| rd_addr | output | AW | Read byte address |
| wr_valid | output | 1 | Write address valid |
| wr_ready | input | 1 | Write address accepted |
| wr_addr | output | AW | Write byte address |
| done | output | 1 | Transaction finished (one cycle) |
| done_eof | output | 1 | done qualified by the captured eof flag |

## Verification
Both streams present their first address one cycle after the start edge. Each address moves one cycle after the edge that completed its handshake. done follows the later final handshake by exactly one cycle, and an empty or misfit transaction raises done in the first cycle after start. The bench drives ready on the falling edge and samples one nanosecond later. Every accepted address is compared in order against a computed expectation, and the bench records the cycle index of the last handshake so it can demand that done appears exactly one sampling point later.

// File: rtl/wagen_pkg.sv
package wagen_pkg;

   typedef enum logic [1:0] {
      BPP_ONE   = 2'd0,
      BPP_TWO   = 2'd1,
      BPP_THREE = 2'd2,
      BPP_RSV   = 2'd3
   } bpp_code_e;

   function automatic logic [1:0] bpp_bytes(input logic [1:0] code);
      case (bpp_code_e'(code))
         BPP_TWO:   return 2'd2;
         BPP_THREE: return 2'd3;
         default:   return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/wagen_setup.sv
module wagen_setup
   import wagen_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DIM_W = 14,
   parameter int HI_W  = 10,
   parameter int LO_W  = 14,
   localparam int CNT_W = HI_W + LO_W
) (
   input  logic             mode_2d,
   input  logic [1:0]       bpp_code,
   input  logic [DIM_W-1:0] pic_w,
   input  logic [DIM_W-1:0] pic_h,
   input  logic [DIM_W-1:0] blk_w,
   input  logic [DIM_W-1:0] blk_h,
   input  logic [DIM_W-1:0] off_x,
   input  logic [DIM_W-1:0] off_y,
   input  logic [HI_W-1:0]  len_hi,
   input  logic [LO_W-1:0]  len_lo,
   input  logic [AW-1:0]    src_base,
   input  logic [AW-1:0]    dst_base,
   output logic [AW-1:0]    src_origin,
   output logic [AW-1:0]    dst_origin,
   output logic [AW-1:0]    src_stride,
   output logic [AW-1:0]    dst_stride,
   output logic [CNT_W-1:0] row_bytes,
   output logic [DIM_W-1:0] rows,
   output logic             empty
);

   logic [CNT_W-1:0] bpp_c;
   logic [AW-1:0]    bpp_a;
   logic [CNT_W-1:0] w_bytes;
   logic [CNT_W-1:0] lin_len;
   logic [AW-1:0]    win_off;
   logic             fits_x, fits_y, zero_2d;

   assign bpp_c   = CNT_W'(bpp_bytes(bpp_code));
   assign bpp_a   = AW'(bpp_bytes(bpp_code));
   assign w_bytes = CNT_W'(blk_w) * bpp_c;
   assign lin_len = {len_hi, len_lo};
   assign win_off = (AW'(off_y) * AW'(pic_w) + AW'(off_x)) * bpp_a;

   assign fits_x  = ({1'b0, off_x} + {1'b0, blk_w}) <= {1'b0, pic_w};
   assign fits_y  = ({1'b0, off_y} + {1'b0, blk_h}) <= {1'b0, pic_h};
   assign zero_2d = (blk_w == '0) || (blk_h == '0);

   always_comb begin
      src_origin = src_base;
      if (mode_2d) begin
         dst_origin = dst_base + win_off;
         src_stride = AW'(w_bytes);
         dst_stride = AW'(pic_w) * bpp_a;
         row_bytes  = w_bytes;
         rows       = blk_h;
         empty      = zero_2d || !fits_x || !fits_y;
      end else begin
         dst_origin = dst_base;
         src_stride = '0;
         dst_stride = '0;
         row_bytes  = lin_len;
         rows       = DIM_W'(1);
         empty      = (lin_len == '0);
      end
   end

endmodule

// File: rtl/wagen_walker.sv
module wagen_walker #(
   parameter int AW    = 32,
   parameter int CNT_W = 24,
   parameter int ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    origin,
   input  logic [AW-1:0]    stride,
   input  logic [CNT_W-1:0] row_bytes,
   input  logic [ROW_W-1:0] rows,
   input  logic             ready,
   output logic             valid,
   output logic [AW-1:0]    addr
);

   logic             active;
   logic [AW-1:0]    cur, row_base, stride_q;
   logic [CNT_W-1:0] rowb_q, bcnt;
   logic [ROW_W-1:0] rows_q, rcnt;
   logic             row_end, last_row;

   assign row_end  = (bcnt == rowb_q - CNT_W'(1));
   assign last_row = (rcnt == rows_q - ROW_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur      <= '0;
         row_base <= '0;
         stride_q <= '0;
         rowb_q   <= '0;
         rows_q   <= '0;
         bcnt     <= '0;
         rcnt     <= '0;
      end else if (load) begin
         active   <= 1'b1;
         cur      <= origin;
         row_base <= origin;
         stride_q <= stride;
         rowb_q   <= row_bytes;
         rows_q   <= rows;
         bcnt     <= '0;
         rcnt     <= '0;
      end else if (active && ready) begin
         if (row_end) begin
            if (last_row) begin
               active <= 1'b0;
            end else begin
               rcnt     <= rcnt + ROW_W'(1);
               bcnt     <= '0;
               row_base <= row_base + stride_q;
               cur      <= row_base + stride_q;
            end
         end else begin
            bcnt <= bcnt + CNT_W'(1);
            cur  <= cur + AW'(1);
         end
      end
   end

   assign valid = active;
   assign addr  = cur;

endmodule

// File: rtl/win_dma_agen.sv
module win_dma_agen
   import wagen_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DIM_W = 14,
   parameter int HI_W  = 10,
   parameter int LO_W  = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mode_2d,
   input  logic             eof_flag,
   input  logic [1:0]       bpp_code,
   input  logic [DIM_W-1:0] pic_w,
   input  logic [DIM_W-1:0] pic_h,
   input  logic [DIM_W-1:0] blk_w,
   input  logic [DIM_W-1:0] blk_h,
   input  logic [DIM_W-1:0] off_x,
   input  logic [DIM_W-1:0] off_y,
   input  logic [HI_W-1:0]  len_hi,
   input  logic [LO_W-1:0]  len_lo,
   input  logic [AW-1:0]    src_base,
   input  logic [AW-1:0]    dst_base,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [AW-1:0]    rd_addr,
   output logic             wr_valid,
   input  logic             wr_ready,
   output logic [AW-1:0]    wr_addr,
   output logic             done,
   output logic             done_eof
);

   localparam int CNT_W  = HI_W + LO_W;
   localparam int NSIDE  = 2;
   localparam int SIDE_R = 0;
   localparam int SIDE_W = 1;

   if (LO_W != 14) begin : g_bad_lo
      $error("win_dma_agen: LO_W must be 14");
   end
   if (CNT_W < DIM_W + 2) begin : g_bad_cnt
      $error("win_dma_agen: HI_W+LO_W too narrow for a row of 3-byte pixels");
   end
   if (AW < 2 * DIM_W + 2 || AW < CNT_W + 1) begin : g_bad_aw
      $error("win_dma_agen: AW too narrow for the picture or linear length");
   end

   logic [AW-1:0]    src_origin, dst_origin, src_stride, dst_stride;
   logic [CNT_W-1:0] row_bytes;
   logic [DIM_W-1:0] rows;
   logic             empty;

   wagen_setup #(
      .AW(AW), .DIM_W(DIM_W), .HI_W(HI_W), .LO_W(LO_W)
   ) u_setup (
      .mode_2d   (mode_2d),
      .bpp_code  (bpp_code),
      .pic_w     (pic_w),
      .pic_h     (pic_h),
      .blk_w     (blk_w),
      .blk_h     (blk_h),
      .off_x     (off_x),
      .off_y     (off_y),
      .len_hi    (len_hi),
      .len_lo    (len_lo),
      .src_base  (src_base),
      .dst_base  (dst_base),
      .src_origin(src_origin),
      .dst_origin(dst_origin),
      .src_stride(src_stride),
      .dst_stride(dst_stride),
      .row_bytes (row_bytes),
      .rows      (rows),
      .empty     (empty)
   );

   logic          busy, eof_q, load;
   logic [AW-1:0] side_org [NSIDE];
   logic [AW-1:0] side_str [NSIDE];
   logic [AW-1:0] side_adr [NSIDE];
   logic          side_rdy [NSIDE];
   logic          side_vld [NSIDE];

   assign load = !busy && start && !empty;

   assign side_org[SIDE_R] = src_origin;
   assign side_org[SIDE_W] = dst_origin;
   assign side_str[SIDE_R] = src_stride;
   assign side_str[SIDE_W] = dst_stride;
   assign side_rdy[SIDE_R] = rd_ready;
   assign side_rdy[SIDE_W] = wr_ready;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      wagen_walker #(
         .AW(AW), .CNT_W(CNT_W), .ROW_W(DIM_W)
      ) u_walk (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .origin   (side_org[s]),
         .stride   (side_str[s]),
         .row_bytes(row_bytes),
         .rows     (rows),
         .ready    (side_rdy[s]),
         .valid    (side_vld[s]),
         .addr     (side_adr[s])
      );
   end

   assign rd_valid = side_vld[SIDE_R];
   assign rd_addr  = side_adr[SIDE_R];
   assign wr_valid = side_vld[SIDE_W];
   assign wr_addr  = side_adr[SIDE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         eof_q <= 1'b0;
      end else if (!busy && start) begin
         busy  <= 1'b1;
         eof_q <= eof_flag;
      end else if (done) begin
         busy  <= 1'b0;
      end
   end

   assign done     = busy && !side_vld[SIDE_R] && !side_vld[SIDE_W];
   assign done_eof = done && eof_q;

endmodule

// File: rtl/wagen_chk.sv
module wagen_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic [AW-1:0] rd_addr,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic [AW-1:0] wr_addr,
   input logic          done,
   input logic          done_eof
);

   p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr))
      else $error("read address moved without a handshake");

   p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr))
      else $error("write address moved without a handshake");

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   p_eof_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_eof |-> done)
      else $error("done_eof without done");

   p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_valid && !wr_valid)
      else $error("stream valid during done");

   p_rd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready |=> !rd_valid || (rd_addr != $past(rd_addr)))
      else $error("read address repeated after a handshake");

endmodule

bind win_dma_agen wagen_chk #(.AW(AW)) u_wagen_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_valid(rd_valid),
   .rd_ready(rd_ready),
   .rd_addr (rd_addr),
   .wr_valid(wr_valid),
   .wr_ready(wr_ready),
   .wr_addr (wr_addr),
   .done    (done),
   .done_eof(done_eof)
);

// File: tb/test_win_dma_agen.sv
`timescale 1ns/1ps
module test_win_dma_agen;

   localparam int AW = 32, DIM_W = 14, HI_W = 10, LO_W = 14;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic mode_2d = 1'b0, eof_flag = 1'b0;
   logic [1:0] bpp_code = '0;
   logic [DIM_W-1:0] pic_w = '0, pic_h = '0, blk_w = '0, blk_h = '0, off_x = '0, off_y = '0;
   logic [HI_W-1:0] len_hi = '0;
   logic [LO_W-1:0] len_lo = '0;
   logic [AW-1:0] src_base = '0, dst_base = '0;
   logic rd_valid, rd_ready = 1'b0, wr_valid, wr_ready = 1'b0, done, done_eof;
   logic [AW-1:0] rd_addr, wr_addr;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   win_dma_agen #(.AW(AW), .DIM_W(DIM_W), .HI_W(HI_W), .LO_W(LO_W)) i_win_dma_agen (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_2d(mode_2d), .eof_flag(eof_flag),
      .bpp_code(bpp_code), .pic_w(pic_w), .pic_h(pic_h), .blk_w(blk_w), .blk_h(blk_h),
      .off_x(off_x), .off_y(off_y), .len_hi(len_hi), .len_lo(len_lo),
      .src_base(src_base), .dst_base(dst_base),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .done(done), .done_eof(done_eof));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int bpp_of(input logic [1:0] c);
      return (c == 2'd1) ? 2 : (c == 2'd2) ? 3 : 1;
   endfunction

   // expectation snapshot, taken when a start is launched
   bit e_2d, e_eof;
   int e_bpp, e_pw, e_ph, e_bw, e_bh, e_x, e_y, e_len;
   longint e_src, e_dst;

   function automatic bit exp_empty();
      if (e_2d) return (e_bw == 0) || (e_bh == 0) || (e_x + e_bw > e_pw) || (e_y + e_bh > e_ph);
      return e_len == 0;
   endfunction

   function automatic int exp_count();
      if (exp_empty()) return 0;
      return e_2d ? e_bw * e_bh * e_bpp : e_len;
   endfunction

   function automatic longint exp_wr(input int n);
      int pix, k, wx, wy;
      if (!e_2d) return e_dst + n;
      pix = n / e_bpp; k = n % e_bpp;
      wy = pix / e_bw; wx = pix % e_bw;
      return e_dst + longint'(e_pw * (e_y + wy) + e_x + wx) * e_bpp + k;
   endfunction

   // run one transaction; rnd selects random ready, poke fires a start while busy
   task automatic run_txn(input string tag, input bit rnd, input bit poke);
      int rd_n = 0, wr_n = 0, cyc = 0, last_hs = -1, cnt;
      bit got_done = 0;
      logic [AW-1:0] keep_dst;
      e_2d = mode_2d; e_eof = eof_flag; e_bpp = bpp_of(bpp_code);
      e_pw = pic_w; e_ph = pic_h; e_bw = blk_w; e_bh = blk_h; e_x = off_x; e_y = off_y;
      e_len = int'({len_hi, len_lo}); e_src = src_base; e_dst = dst_base;
      cnt = exp_count();
      keep_dst = dst_base;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!got_done && cyc < 40000) begin
         rd_ready = rnd ? 1'($urandom % 4 != 0) : 1'b1;
         wr_ready = rnd ? 1'($urandom % 3 != 0) : 1'b1;
         if (poke && cyc == 3) begin
            start = 1'b1; dst_base = dst_base + 32'h100; mode_2d = ~mode_2d;   // R9 stimulus
         end
         if (poke && cyc == 4) begin
            start = 1'b0; dst_base = keep_dst; mode_2d = ~mode_2d;
         end
         #1;
         if (done) begin
            got_done = 1;
            chk(rd_n == cnt, {tag, " R2/R6 read count"}, rd_n, cnt);
            chk(wr_n == cnt, {tag, " R4/R6 write count"}, wr_n, cnt);
            chk(cyc == last_hs + 1, {tag, " R8/R10/R11 done timing"}, cyc, last_hs + 1);
            chk(done_eof == e_eof, {tag, " R8 done_eof"}, done_eof, e_eof);
         end else begin
            if (rd_valid && rd_ready) begin
               chk(rd_n < cnt && rd_addr == e_src + rd_n, {tag, " R2/R6/R7 read addr"}, rd_addr, e_src + rd_n);
               rd_n++; last_hs = cyc;
            end
            if (wr_valid && wr_ready) begin
               chk(wr_n < cnt && wr_addr == exp_wr(wr_n), {tag, " R3/R4/R5/R6/R7 write addr"}, wr_addr, exp_wr(wr_n));
               wr_n++; last_hs = cyc;
            end
         end
         @(negedge clk); cyc++;
      end
      chk(got_done, {tag, " R8 done seen"}, got_done, 1);
      rd_ready = 1'b1; wr_ready = 1'b1;
      for (int i = 0; i < 3; i++) begin
         #1;
         chk(!rd_valid && !wr_valid && !done, {tag, " R9 idle after done"}, {rd_valid, wr_valid, done}, 0);
         @(negedge clk);
      end
   endtask

   task automatic set2d(input int pw, ph, bw, bh, x, y, input logic [1:0] code, input bit eof);
      mode_2d = 1'b1; pic_w = DIM_W'(pw); pic_h = DIM_W'(ph); blk_w = DIM_W'(bw); blk_h = DIM_W'(bh);
      off_x = DIM_W'(x); off_y = DIM_W'(y); bpp_code = code; eof_flag = eof;
      src_base = $urandom & 32'h00FF_FFF0; dst_base = $urandom & 32'h00FF_FFF0;
      len_hi = HI_W'($urandom); len_lo = LO_W'($urandom);  // R6: unused in 2D
   endtask

   initial begin
      #(4 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_2D01));
      repeat (3) @(negedge clk);
      #1;
      chk(!rd_valid && !wr_valid && !done, "R1 reset outputs", {rd_valid, wr_valid, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(!rd_valid && !wr_valid && !done, "R1 idle after reset", {rd_valid, wr_valid, done}, 0);

      set2d(8, 8, 2, 2, 2, 4, 2'd1, 1'b1); run_txn("win8x8", 0, 0);
      set2d(8, 8, 2, 2, 2, 4, 2'd1, 1'b0); run_txn("win8x8 rnd", 1, 0);
      set2d(6, 5, 3, 2, 1, 1, 2'd0, 1'b1); run_txn("R5 bpp1", 1, 0);
      set2d(6, 5, 3, 2, 3, 3, 2'd2, 1'b1); run_txn("R5 bpp3 edgefit", 1, 0);
      set2d(6, 5, 3, 2, 0, 0, 2'd3, 1'b0); run_txn("R5 reserved", 0, 0);
      set2d(7, 7, 1, 7, 6, 0, 2'd1, 1'b1); run_txn("R3 column", 1, 0);
      set2d(9, 9, 4, 3, 2, 2, 2'd2, 1'b1); run_txn("R9 busy start", 0, 1);
      set2d(8, 8, 0, 3, 0, 0, 2'd1, 1'b1); run_txn("R10 zero width", 1, 0);
      set2d(8, 8, 3, 0, 0, 0, 2'd1, 1'b1); run_txn("R10 zero height", 1, 0);
      set2d(8, 8, 3, 2, 6, 0, 2'd1, 1'b1); run_txn("R11 misfit x", 1, 0);
      set2d(8, 8, 3, 2, 0, 7, 2'd1, 1'b1); run_txn("R11 misfit y", 1, 0);

      mode_2d = 1'b0; len_hi = 10'd1; len_lo = 14'd5; bpp_code = 2'd2; eof_flag = 1'b1;
      src_base = 32'h0001_0000; dst_base = 32'h0020_0003; run_txn("R6 linear hi", 0, 0);
      len_hi = '0; len_lo = 14'd37; bpp_code = 2'd1; run_txn("R6 linear rnd", 1, 0);
      len_hi = '0; len_lo = '0; run_txn("R10 zero length", 1, 0);

      for (int t = 0; t < 30; t++) begin
         int pw = 1 + $urandom % 12, ph = 1 + $urandom % 10;
         int bw = $urandom % (pw + 1), bh = $urandom % (ph + 1);
         set2d(pw, ph, bw, bh, $urandom % (pw - bw + 1), $urandom % (ph - bh + 1),
               2'($urandom), 1'($urandom));
         run_txn("R3 random", 1, 0);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule